// File: doc/BRIEF.md
# Energy-Efficient Ethernet Low-Power-Idle Controller

This block decides when the transmit side of an Ethernet MAC enters and leaves low-power idle (LPI), and it records LPI entry and exit events for both transmit and receive. Software programs two guard times through one packed timer word. The first is a link-stable time in milliseconds that the PHY link must stay good before LPI may start. The second is a wake time in microseconds that must pass after LPI ends before frames may be sent again. A free-running prescaler, parameterised by the clock rate, makes the microsecond and millisecond ticks.

Two entry modes exist. In automatic mode the transmitter stays in LPI only while the MAC reports an idle transmit path. In manual mode the request bit alone holds LPI, and the idle indication is ignored. Four event bits are latched and cleared by a status read. Their OR forms a summary interrupt.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset `lpi_assert` is 0, `tx_allowed` is 1, `stat` is 0 and `lpi_irq` is 0.
- R2: When `timer_wr` is 1 at a clock edge, `timer_wdata[15:0]` is stored as the wake time in microseconds and `timer_wdata[26:16]` is stored as the link-stable time in milliseconds. Both stored values are used from the next cycle on.
- R3: While `link_up` is 0 the link-stable count is held at zero. While `link_up` is 1 the count rises by one on each millisecond tick and saturates at 2047. The link counts as stable only while `link_up` is 1 and the count is at least the link-stable time. LPI is never entered unless the link is stable.
- R4: In automatic mode (`auto_tx`=1), the block enters LPI when `lpi_en`, `tx_idle` and link stability are all true. `lpi_assert` rises and `tx_allowed` falls one clock after that condition is sampled.
- R5: In manual mode (`auto_tx`=0), `tx_idle` has no effect: LPI is entered and held while `lpi_en` and link stability are true.
- R6: When the hold condition drops during LPI, `lpi_assert` falls on the next clock and the wake counter loads the wake time. The counter decrements on each microsecond tick. `tx_allowed` rises one clock after the counter reads zero, and it stays 0 until then.
- R7: `lpi_assert` and `tx_allowed` are never 1 together.
- R8: `stat` bit 0 is transmit-entered-LPI, bit 1 is transmit-left-LPI, bit 2 is receive-entered-LPI (rising `rx_lpi`) and bit 3 is receive-left-LPI (falling `rx_lpi`). Each bit sets at the same clock edge as its event and stays set until a read.
- R9: A clock edge with `stat_rd`=1 replaces `stat` with only the events of that same edge, so new events survive a read. `lpi_irq` is the OR of the `stat` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lpi_en | input | 1 | LPI request bit |
| auto_tx | input | 1 | 1: hold LPI only while transmit path idle |
| link_up | input | 1 | Software-written PHY link-good bit |
| timer_wr | input | 1 | Load strobe for the timer word |
| timer_wdata | input | 27 | [26:16] link-stable ms, [15:0] wake us |
| tx_idle | input | 1 | MAC transmit path is idle |
| rx_lpi | input | 1 | Receive side is in LPI |
| stat_rd | input | 1 | Status read strobe, clears latched events |
| lpi_assert | output | 1 | LPI request to the PHY interface |
| tx_allowed | output | 1 | Normal transmission permitted |
| stat | output | 4 | Latched events: rx-exit, rx-enter, tx-exit, tx-enter |
| lpi_irq | output | 1 | Summary LPI interrupt |

## Verification
The controller runs through an automatic-mode entry that starts with the link down, then with the link just raised, then with the link stable. This shows that entry waits for the millisecond guard and does not wait on the request alone. Manual mode is run with `tx_idle` toggling, which shows that the idle input is ignored there and not in automatic mode. Exits are taken with a nonzero wake time and with a zero wake time, which separates the microsecond countdown from the one-cycle path back to transmit. A read is issued in the same cycle as a receive event, which shows that a new event survives the clear.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;
  localparam int TW_W = 16;
  localparam int LS_W = 11;
  localparam int TIMER_W = TW_W + LS_W;
  localparam int EV_W = 4;
  localparam int EV_TX_IN = 0;
  localparam int EV_TX_OUT = 1;
  localparam int EV_RX_IN = 2;
  localparam int EV_RX_OUT = 3;

  typedef enum logic [1:0] {
    TX_ACTIVE = 2'd0,
    TX_LPI    = 2'd1,
    TX_WAKE   = 2'd2
  } tx_state_e;

  function automatic logic [TW_W-1:0] wake_field(input logic [TIMER_W-1:0] w);
    return w[TW_W-1:0];
  endfunction

  function automatic logic [LS_W-1:0] stable_field(input logic [TIMER_W-1:0] w);
    return w[TIMER_W-1:TW_W];
  endfunction

  // hold condition for low-power idle on the transmit side
  function automatic logic hold_lpi(input logic en, input logic auto_m,
                                    input logic idle, input logic stable);
    return en && stable && (auto_m ? idle : 1'b1);
  endfunction
endpackage

// File: rtl/eee_tick_gen.sv
module eee_tick_gen #(
  parameter int CLK_PER_US = 250,
  parameter int US_PER_MS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic us_tick,
  output logic ms_tick
);
  localparam int US_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int MS_W = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;

  logic [US_W-1:0] us_cnt;
  logic [MS_W-1:0] ms_cnt;
  logic us_last, ms_last;

  assign us_last = (us_cnt == US_W'(CLK_PER_US - 1));
  assign ms_last = (ms_cnt == MS_W'(US_PER_MS - 1));
  assign us_tick = us_last;
  assign ms_tick = us_last && ms_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      us_cnt <= '0;
      ms_cnt <= '0;
    end else begin
      us_cnt <= us_last ? '0 : us_cnt + 1'b1;
      if (us_last) ms_cnt <= ms_last ? '0 : ms_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/eee_link_guard.sv
module eee_link_guard
  import eee_lpi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            link_up,
  input  logic            ms_tick,
  input  logic [LS_W-1:0] ls_time,
  output logic            link_stable
);
  logic [LS_W-1:0] ls_cnt;
  logic ls_sat;

  assign ls_sat = &ls_cnt;
  assign link_stable = link_up && (ls_cnt >= ls_time);

  always_ff @(posedge clk) begin
    if (!rst_n) ls_cnt <= '0;
    else if (!link_up) ls_cnt <= '0;
    else if (ms_tick && !ls_sat) ls_cnt <= ls_cnt + 1'b1;
  end
endmodule

// File: rtl/eee_tx_fsm.sv
module eee_tx_fsm
  import eee_lpi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            us_tick,
  input  logic [TW_W-1:0] tw_time,
  output logic            lpi_on,
  output logic            tx_ok,
  output logic            ev_enter,
  output logic            ev_leave
);
  tx_state_e st, st_nxt;
  logic [TW_W-1:0] wcnt;
  logic wake_done;

  assign wake_done = (wcnt == '0);

  always_comb begin
    st_nxt = st;
    ev_enter = 1'b0;
    ev_leave = 1'b0;
    case (st)
      TX_ACTIVE: if (hold) begin st_nxt = TX_LPI; ev_enter = 1'b1; end
      TX_LPI:    if (!hold) begin st_nxt = TX_WAKE; ev_leave = 1'b1; end
      TX_WAKE:   if (wake_done) st_nxt = TX_ACTIVE;
      default:   st_nxt = TX_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= TX_ACTIVE;
      wcnt <= '0;
    end else begin
      st <= st_nxt;
      if (ev_leave) wcnt <= tw_time;
      else if (st == TX_WAKE && us_tick && !wake_done) wcnt <= wcnt - 1'b1;
    end
  end

  assign lpi_on = (st == TX_LPI);
  assign tx_ok = (st == TX_ACTIVE);
endmodule

// File: rtl/eee_event_log.sv
module eee_event_log
  import eee_lpi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_in,
  input  logic            tx_out,
  input  logic            rx_lpi,
  input  logic            rd,
  output logic [EV_W-1:0] ev,
  output logic [EV_W-1:0] flags
);
  logic rx_q;

  always_comb begin
    ev = '0;
    ev[EV_TX_IN] = tx_in;
    ev[EV_TX_OUT] = tx_out;
    ev[EV_RX_IN] = rx_lpi && !rx_q;
    ev[EV_RX_OUT] = !rx_lpi && rx_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q <= 1'b0;
      flags <= '0;
    end else begin
      rx_q <= rx_lpi;
      flags <= rd ? ev : (flags | ev);
    end
  end
endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
  import eee_lpi_pkg::*;
#(
  parameter int CLK_PER_US = 250,
  parameter int US_PER_MS = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lpi_en,
  input  logic               auto_tx,
  input  logic               link_up,
  input  logic               timer_wr,
  input  logic [TIMER_W-1:0] timer_wdata,
  input  logic               tx_idle,
  input  logic               rx_lpi,
  input  logic               stat_rd,
  output logic               lpi_assert,
  output logic               tx_allowed,
  output logic [EV_W-1:0]    stat,
  output logic               lpi_irq
);
  logic [TW_W-1:0] tw_time;
  logic [LS_W-1:0] ls_time;
  logic us_tick, ms_tick, link_stable, hold;
  logic ev_enter, ev_leave;
  logic [EV_W-1:0] ev_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tw_time <= '0;
      ls_time <= '0;
    end else if (timer_wr) begin
      tw_time <= wake_field(timer_wdata);
      ls_time <= stable_field(timer_wdata);
    end
  end

  eee_tick_gen #(.CLK_PER_US(CLK_PER_US), .US_PER_MS(US_PER_MS)) u_ticks (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ms_tick(ms_tick));

  eee_link_guard u_guard (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .ms_tick(ms_tick),
    .ls_time(ls_time), .link_stable(link_stable));

  assign hold = hold_lpi(lpi_en, auto_tx, tx_idle, link_stable);

  eee_tx_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hold(hold), .us_tick(us_tick), .tw_time(tw_time),
    .lpi_on(lpi_assert), .tx_ok(tx_allowed), .ev_enter(ev_enter), .ev_leave(ev_leave));

  eee_event_log u_log (
    .clk(clk), .rst_n(rst_n), .tx_in(ev_enter), .tx_out(ev_leave), .rx_lpi(rx_lpi),
    .rd(stat_rd), .ev(ev_vec), .flags(stat));

  assign lpi_irq = |stat;
endmodule

// File: rtl/eee_lpi_chk.sv
module eee_lpi_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lpi_assert,
  input logic       tx_allowed,
  input logic       link_up,
  input logic       stat_rd,
  input logic [3:0] stat,
  input logic [3:0] ev
);
  // R7
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lpi_assert && tx_allowed));
  // R3
  entry_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lpi_assert) |-> $past(link_up));
  // R8
  entry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lpi_assert) |-> stat[0]);
  // R6
  wake_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lpi_assert) |-> !tx_allowed && stat[1]);
  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && ev == 4'b0) |=> stat == 4'b0);
endmodule

bind eee_lpi_ctrl eee_lpi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lpi_assert(lpi_assert), .tx_allowed(tx_allowed),
  .link_up(link_up), .stat_rd(stat_rd), .stat(stat), .ev(ev_vec));

// File: tb/eee_lpi_ctrl_test.sv
module eee_lpi_ctrl_test;
  localparam int CPU = 4;
  localparam int UPM = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lpi_en = 0, auto_tx = 0, link_up = 0, timer_wr = 0, tx_idle = 0, rx_lpi = 0, stat_rd = 0;
  logic [26:0] timer_wdata = '0;
  logic lpi_assert, tx_allowed, lpi_irq;
  logic [3:0] stat;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  eee_lpi_ctrl #(.CLK_PER_US(CPU), .US_PER_MS(UPM)) uut (
    .clk(clk), .rst_n(rst_n), .lpi_en(lpi_en), .auto_tx(auto_tx), .link_up(link_up),
    .timer_wr(timer_wr), .timer_wdata(timer_wdata), .tx_idle(tx_idle), .rx_lpi(rx_lpi),
    .stat_rd(stat_rd), .lpi_assert(lpi_assert), .tx_allowed(tx_allowed), .stat(stat),
    .lpi_irq(lpi_irq));

  // behavioural reference model
  int m_us, m_ms, m_ls, m_lst, m_tw, m_st, m_w, m_rxp;
  logic [3:0] m_stat;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_us = 0; m_ms = 0; m_ls = 0; m_lst = 0; m_tw = 0; m_st = 0; m_w = 0; m_rxp = 0;
      m_stat = 4'b0;
    end else begin
      bit ut, mt, stable, stay;
      int n_st, n_w;
      logic [3:0] ev;
      ut = (m_us == CPU - 1);
      mt = ut && (m_ms == UPM - 1);
      stable = link_up && (m_ls >= m_lst);
      stay = lpi_en && stable && (!auto_tx || tx_idle);
      ev = 4'b0;
      n_st = m_st;
      n_w = m_w;
      if (m_st == 0) begin
        if (stay) begin n_st = 1; ev[0] = 1'b1; end
      end else if (m_st == 1) begin
        if (!stay) begin n_st = 2; ev[1] = 1'b1; n_w = m_tw; end
      end else begin
        if (m_w == 0) n_st = 0;
        else if (ut) n_w = m_w - 1;
      end
      if (rx_lpi && m_rxp == 0) ev[2] = 1'b1;
      if (!rx_lpi && m_rxp == 1) ev[3] = 1'b1;
      m_stat = stat_rd ? ev : (m_stat | ev);
      m_st = n_st;
      m_w = n_w;
      if (!link_up) m_ls = 0;
      else if (mt && m_ls < 2047) m_ls = m_ls + 1;
      if (timer_wr) begin
        m_tw = int'(timer_wdata[15:0]);
        m_lst = int'(timer_wdata[26:16]);
      end
      m_us = ut ? 0 : m_us + 1;
      if (ut) m_ms = (m_ms == UPM - 1) ? 0 : m_ms + 1;
      m_rxp = rx_lpi ? 1 : 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(lpi_assert == (m_st == 1), "R4 model lpi_assert", int'(lpi_assert), int'(m_st == 1));
      chk(tx_allowed == (m_st == 0), "R6 model tx_allowed", int'(tx_allowed), int'(m_st == 0));
      chk(stat == m_stat, "R8 model stat", int'(stat), int'(m_stat));
      chk(lpi_irq == (|m_stat), "R9 model irq", int'(lpi_irq), int'(|m_stat));
      chk(!(lpi_assert && tx_allowed), "R7 exclusive", int'(lpi_assert), 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_stat();
    stat_rd = 1; cyc(1); stat_rd = 0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk(lpi_assert == 0, "R1 reset lpi", int'(lpi_assert), 0);
    chk(tx_allowed == 1, "R1 reset tx", int'(tx_allowed), 1);
    chk(stat == 0 && lpi_irq == 0, "R1 reset stat", int'(stat), 0);

    // R2: link-stable 2 ms, wake 3 us
    timer_wdata = {11'd2, 16'd3}; timer_wr = 1; cyc(1); timer_wr = 0;

    // automatic mode, link down
    lpi_en = 1; auto_tx = 1; tx_idle = 1;
    cyc(10);
    chk(lpi_assert == 0, "R3 link down blocks", int'(lpi_assert), 0);
    link_up = 1;
    cyc(10);
    chk(lpi_assert == 0, "R3 before guard", int'(lpi_assert), 0);
    cyc(40);
    chk(lpi_assert == 1, "R4 auto entry", int'(lpi_assert), 1);
    chk(stat[0] == 1 && lpi_irq == 1, "R8 tx enter flag", int'(stat), 1);
    read_stat();
    chk(stat == 0 && lpi_irq == 0, "R9 read clears", int'(stat), 0);

    // exit by transmit activity
    tx_idle = 0;
    cyc(1);
    chk(lpi_assert == 0 && tx_allowed == 0, "R6 exit starts wake", int'(tx_allowed), 0);
    chk(stat[1] == 1, "R8 tx exit flag", int'(stat), 2);
    cyc(5);
    chk(tx_allowed == 0, "R6 wake hold", int'(tx_allowed), 0);
    cyc(16);
    chk(tx_allowed == 1, "R6 wake done", int'(tx_allowed), 1);
    read_stat();

    // manual mode ignores tx_idle
    auto_tx = 0;
    cyc(2);
    chk(lpi_assert == 1, "R5 manual entry", int'(lpi_assert), 1);
    tx_idle = 1; cyc(2); tx_idle = 0; cyc(2);
    chk(lpi_assert == 1, "R5 idle ignored", int'(lpi_assert), 1);

    // receive events, one coinciding with a read
    rx_lpi = 1; stat_rd = 1; cyc(1); stat_rd = 0;
    chk(stat == 4'b0100, "R9 event survives read", int'(stat), 4);
    rx_lpi = 0; cyc(1);
    chk(stat[3] == 1, "R8 rx exit flag", int'(stat), 12);

    // zero wake time
    timer_wdata = {11'd0, 16'd0}; timer_wr = 1; cyc(1); timer_wr = 0;
    lpi_en = 0; cyc(2);
    chk(tx_allowed == 1, "R6 zero wake", int'(tx_allowed), 1);

    // link flap restarts guard
    timer_wdata = {11'd2, 16'd1}; timer_wr = 1; cyc(1); timer_wr = 0;
    link_up = 0; cyc(2); link_up = 1; lpi_en = 1;
    cyc(10);
    chk(lpi_assert == 0, "R3 guard restarted", int'(lpi_assert), 0);
    cyc(40);
    chk(lpi_assert == 1, "R3 entry after guard", int'(lpi_assert), 1);
    link_up = 0; cyc(1);
    chk(lpi_assert == 0, "R3 link drop exits", int'(lpi_assert), 0);
    cyc(10);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule